// File: doc/BRIEF.md
# Cell-Grid Unsigned Multiplier

This block multiplies two unsigned operands of equal width `W` and presents the full-width product. It has no clock and no state. The product is valid one propagation delay after the operands settle.

The product comes from a two-dimensional mesh of identical cells rather than from an arithmetic operator. Each cell forms one AND partial-product bit. It adds that bit to an incoming partial sum and carry, and hands its operand bits, its carry and its sum on to neighbouring cells.

Grid rows follow multiplier bits and grid columns follow multiplicand bits. Every row either adds the multiplicand or adds zero, and retires one low product bit from its first column. The sums and carries left in the last row are resolved by a ripple chain built from the same cell, which yields the upper half of the product.

Top module: `amul_array`

## Requirements
- R1: `prod_o` equals the unsigned integer product `a_i * b_i` for every operand pair.
- R2: Product bit 0 equals `a_i[0] AND b_i[0]`.
- R3: When either operand is zero, `prod_o` is zero.
- R4: When one operand equals 1, `prod_o` equals the other operand, zero-extended to 2W bits.
- R5: Every multiplicand bit reaches every grid row unchanged, and every multiplier bit reaches every grid column unchanged. With both operands all ones, the product is (2^W-1)^2.
- R6: The final ripple chain never produces a carry beyond bit 2W-1. The largest product, (2^W-1)^2, fits in 2W bits.
- R7: The output follows an operand change without any clock edge; the block holds no state.
- R8: With W = 4, operands 4'b1010 and 4'b1001 give 8'b01011010 (90).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Multiplicand, unsigned |
| b_i | input | W | Multiplier, unsigned |
| prod_o | output | 2*W | Unsigned product |

## Verification
Immediate assertions re-evaluate whenever the operands move. They cover the following:
- the zero and identity products;
- the low product bit;
- unchanged delivery of operand bits to the far edges of the grid;
- the absence of a carry out of the final ripple chain.

Full arithmetic correctness across all operand pairs can only be shown by the bench's exhaustive sweep against integer products. The same holds for the specific 10 × 9 case and for outputs changing with no clock edge.

// File: rtl/amul_pkg.sv
package amul_pkg;
  // {carry, sum} of three one-bit addends
  function automatic logic [1:0] fa(input logic a, input logic b, input logic c);
    fa = {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction
endpackage

// File: rtl/amul_cell.sv
module amul_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic p_i,
  input  logic c_i,
  output logic x_o,
  output logic y_o,
  output logic s_o,
  output logic c_o
);
  logic pp;
  assign pp        = x_i & y_i;
  assign {c_o, s_o} = amul_pkg::fa(pp, p_i, c_i);
  assign x_o       = x_i;
  assign y_o       = y_i;
endmodule

// File: rtl/amul_ripple.sv
module amul_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] car_i,
  output logic [W-1:0] hi_o
);
  logic [W:0] rc;
  assign rc[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic xo, yo;
    // y tied high so the cell adds sum_i[k] as its partial-product bit
    amul_cell u_cell (
      .x_i(sum_i[k]), .y_i(1'b1), .p_i(car_i[k]), .c_i(rc[k]),
      .x_o(xo), .y_o(yo), .s_o(hi_o[k]), .c_o(rc[k+1])
    );
    always_comb begin
      if (!$isunknown(sum_i[k]))
        assert (xo == sum_i[k] && yo == 1'b1);
    end
  end

  always_comb begin
    if (!$isunknown({sum_i, car_i})) begin
      // R6
      no_overflow_chk: assert (rc[W] == 1'b0);
    end
  end
endmodule

// File: rtl/amul_array.sv
module amul_array #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic [W-1:0] xq [W+1];   // multiplicand bits entering row j
  logic [W:0]   yq [W];     // multiplier bit entering column i of row j
  logic [W-1:0] s_w [W];
  logic [W-1:0] c_w [W];
  logic [W-1:0] hi;

  assign xq[0] = a_i;

  for (genvar j = 0; j < W; j++) begin : g_row
    assign yq[j][0] = b_i[j];
    for (genvar i = 0; i < W; i++) begin : g_col
      logic p_in, c_in;
      if (j == 0) begin : g_top
        assign p_in = 1'b0;
        assign c_in = 1'b0;
      end else if (i == W-1) begin : g_edge
        assign p_in = 1'b0;
        assign c_in = c_w[j-1][i];
      end else begin : g_mid
        assign p_in = s_w[j-1][i+1];
        assign c_in = c_w[j-1][i];
      end
      amul_cell u_cell (
        .x_i(xq[j][i]), .y_i(yq[j][i]), .p_i(p_in), .c_i(c_in),
        .x_o(xq[j+1][i]), .y_o(yq[j][i+1]), .s_o(s_w[j][i]), .c_o(c_w[j][i])
      );
    end
    assign prod_o[j] = s_w[j][0];
  end

  amul_ripple #(.W(W)) u_ripple (
    .sum_i({1'b0, s_w[W-1][W-1:1]}),
    .car_i(c_w[W-1]),
    .hi_o (hi)
  );
  assign prod_o[PW-1:W] = hi;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R3
      zero_prod_chk: assert (!(a_i == '0 || b_i == '0) || prod_o == '0);
      // R4
      ident_b_chk: assert (b_i != W'(1) || prod_o == PW'(a_i));
      // R4
      ident_a_chk: assert (a_i != W'(1) || prod_o == PW'(b_i));
      // R2
      low_bit_chk: assert (prod_o[0] == (a_i[0] & b_i[0]));
      // R5
      x_fwd_chk: assert (xq[W] == a_i);
      for (int j = 0; j < W; j++) begin
        // R5
        y_fwd_chk: assert (yq[j][W] == b_i[j]);
      end
    end
  end
endmodule

// File: tb/amul_array_tb_top.sv
module amul_array_tb_top;
  localparam int  W        = 4;
  localparam time CLK_PER  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  a, b;
  logic [2*W-1:0] prod;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  amul_array #(.W(W)) dut_i (.a_i(a), .b_i(b), .prod_o(prod));

  task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input int av, input int bv);
    @(posedge clk);
    a = W'(av);
    b = W'(bv);
    @(negedge clk);
  endtask

  initial begin
    a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", prod, '0);

    // R1: exhaustive sweep
    for (int ai = 0; ai < (1 << W); ai++)
      for (int bi = 0; bi < (1 << W); bi++) begin
        apply(ai, bi);
        chk("R1", prod, (2*W)'(ai * bi));
        chk("R2", {7'd0, prod[0]}, {7'd0, a[0] & b[0]});
        if (ai == 0 || bi == 0) chk("R3", prod, '0);
        if (bi == 1) chk("R4", prod, (2*W)'(ai));
        if (ai == 1) chk("R4", prod, (2*W)'(bi));
      end

    apply((1 << W) - 1, (1 << W) - 1);
    chk("R5", prod, (2*W)'(((1 << W) - 1) * ((1 << W) - 1)));
    chk("R6", prod, 8'hE1);

    apply(4'b1010, 4'b1001);
    chk("R8", prod, 8'b01011010);

    // R7: change operands between clock edges, no edge in between
    a = 4'd7; b = 4'd6;
    #1;
    chk("R7", prod, 8'd42);
    a = 4'd13;
    #1;
    chk("R7", prod, 8'd78);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule